// File: doc/BRIEF.md
# Unsigned Radix-4 Booth Partial-Product Rows

This block builds the partial-product rows of an unsigned radix-4 Booth multiplier. Each row takes the N-bit unsigned multiplicand and one overlapping group of three multiplier bits. It recodes that group into select lines that pick one times, two times or zero times the multiplicand, and a negate line. It then decodes the multiplicand into N+1 product bits. Bit N is a redundant copy of the top multiplicand bit, needed when the row holds two times the multiplicand. When the negate line is high, each decoded bit is inverted.

Full sign extension is not used. Each row instead carries a few tail bits above its decoded bits. The first row carries the negate line twice with its inverse on top. Every later row carries the inverted negate line with a constant one above it. The top module instantiates one row per group and sums the rows behaviourally, so the whole arrangement can be checked against a plain product. The shifting and the missing +1 of each negated row are handled in that sum. The block is purely combinational.

Top module: `booth_u4_mul`

## Requirements
- R1: Group k is made of the multiplier bits (y[2k+1], y[2k], y[2k-1]). It selects the digit d = y[2k] + y[2k-1] - 2*y[2k+1]. Bits are recoded as follows: one = y[2k]^y[2k-1]; neg = y[2k+1]; two = NOR(XNOR(y[2k], y[2k+1]), one). Taken as a signed value, {neg, decoded[N:0]} + neg equals d*x.
- R2: Decoded bit 0 of a row is (x[0] & one) ^ neg.
- R3: Decoded bit i, for 1 <= i <= N-1, is ((x[i] & one) | (x[i-1] & two)) ^ neg.
- R4: Decoded bit N is the redundant bit (x[N-1] & two) ^ neg.
- R5: Row 0 holds neg at bit N+1, neg at bit N+2 and ~neg at bit N+3.
- R6: Every row k >= 1 holds ~neg at bit N+1, constant 1 at bit N+2 and 0 at bit N+3.
- R7: The multiplier bit below position 0 is taken as 0, and bits above N-1 are taken as 0. There are (N+2)/2 rows, using integer division. The last row's neg is always 0.
- R8: prod_o equals x_i*y_i exactly. It is the sum of row k shifted left by 2k, plus each row's neg at weight 2k, taken modulo 2^(2N).

Each row occupies RW = N+4 bits of rows_o. Row k sits at rows_o[k*RW +: RW].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Unsigned multiplicand |
| y_i | input | N | Unsigned multiplier |
| rows_o | output | ((N+2)/2)*(N+4) | Concatenated partial-product rows, row 0 at the low end |
| prod_o | output | 2N | Product |

## Verification
Every output is combinational, so each result is due in the same cycle as its stimulus, with zero register stages. The bench changes x_i and y_i just after a rising clock edge. It samples rows_o and prod_o at the following falling edge, so every check reads settled values. Three sizes are checked: N=4 and N=5 swept over all operand pairs, and N=16 with random pairs and the extreme values. The expected rows and product come from the digit arithmetic in R1 and R8.

// File: rtl/booth_u4_pkg.sv
package booth_u4_pkg;
  typedef struct packed {
    logic one;
    logic two;
    logic neg;
    logic neg_n;
  } booth_sel_t;

  function automatic int row_count(input int n);
    return (n + 2) / 2;
  endfunction
endpackage

// File: rtl/booth_u4_recode.sv
module booth_u4_recode
  import booth_u4_pkg::*;
(
  input  logic [2:0]  trip_i,  // {y[2k+1], y[2k], y[2k-1]}
  output booth_sel_t  sel_o
);
  logic one_w;
  assign one_w       = trip_i[0] ^ trip_i[1];
  assign sel_o.one   = one_w;
  assign sel_o.two   = ~((~(trip_i[1] ^ trip_i[2])) | one_w);
  assign sel_o.neg   = trip_i[2];
  assign sel_o.neg_n = ~trip_i[2];
endmodule

// File: rtl/booth_u4_row.sv
module booth_u4_row
  import booth_u4_pkg::*;
#(
  parameter int N          = 8,
  parameter bit FIRST      = 1'b0,
  parameter bit OMIT_NSIGN = 1'b0,
  parameter bit OMIT_ONE   = 1'b0
) (
  input  logic [N-1:0] x_i,
  input  logic [2:0]   trip_i,
  output logic [N+3:0] row_o,
  output logic         neg_o
);
  booth_sel_t sel;

  booth_u4_recode u_rec (.trip_i(trip_i), .sel_o(sel));

  assign row_o[0] = (x_i[0] & sel.one) ^ sel.neg;

  for (genvar i = 1; i < N; i++) begin : g_mid
    assign row_o[i] = ((x_i[i] & sel.one) | (x_i[i-1] & sel.two)) ^ sel.neg;
  end

  // redundant top bit: only reached by the two-times select
  assign row_o[N] = (x_i[N-1] & sel.two) ^ sel.neg;

  if (FIRST) begin : g_first_tail
    assign row_o[N+1] = sel.neg;
    assign row_o[N+2] = sel.neg;
    assign row_o[N+3] = sel.neg_n;
  end else begin : g_tail
    assign row_o[N+1] = OMIT_NSIGN ? 1'b0 : sel.neg_n;
    assign row_o[N+2] = ~OMIT_ONE;
    assign row_o[N+3] = 1'b0;
  end

  assign neg_o = sel.neg;
endmodule

// File: rtl/booth_u4_mul.sv
module booth_u4_mul
  import booth_u4_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]                           x_i,
  input  logic [N-1:0]                           y_i,
  output logic [row_count(N)*(N+4)-1:0]          rows_o,
  output logic [2*N-1:0]                         prod_o
);
  localparam int R  = row_count(N);
  localparam int RW = N + 4;
  localparam int YW = 2 * R + 1;
  localparam int AW = 2 * R + RW;

  logic [YW-1:0] yz;
  logic [R-1:0]  neg;

  assign yz = YW'({y_i, 1'b0});

  for (genvar k = 0; k < R; k++) begin : g_row
    booth_u4_row #(
      .N(N), .FIRST(k == 0), .OMIT_NSIGN(1'b0), .OMIT_ONE(1'b0)
    ) u_row (
      .x_i   (x_i),
      .trip_i(yz[2*k +: 3]),
      .row_o (rows_o[k*RW +: RW]),
      .neg_o (neg[k])
    );
  end

  logic [AW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < R; k++) begin
      acc = acc + (AW'(rows_o[k*RW +: RW]) << (2 * k));
      acc = acc + (AW'(neg[k]) << (2 * k));
    end
  end

  assign prod_o = acc[2*N-1:0];
endmodule

// File: rtl/booth_u4_mul_chk.sv
module booth_u4_mul_chk
  import booth_u4_pkg::*;
#(
  parameter int N = 8
) (
  input logic [N-1:0]                  x_i,
  input logic [N-1:0]                  y_i,
  input logic [row_count(N)*(N+4)-1:0] rows_o,
  input logic [2*N-1:0]                prod_o
);
  localparam int R  = row_count(N);
  localparam int RW = N + 4;

  logic [2*N-1:0] ref_p;
  assign ref_p = (2*N)'(x_i) * (2*N)'(y_i);

  always_comb begin
    assert_prod_exact_R8: assert (prod_o == ref_p)
      else $error("product mismatch");
    assert_first_tail_R5: assert ((rows_o[N+1] == rows_o[N+2]) && (rows_o[N+3] != rows_o[N+1]))
      else $error("row 0 tail malformed");
    assert_last_row_pos_R7: assert (rows_o[(R-1)*RW + N + 1] == ((R == 1) ? 1'b0 : 1'b1))
      else $error("last row negative");
    for (int k = 1; k < R; k++) begin
      assert_tail_const_R6: assert ((rows_o[k*RW + N + 2] == 1'b1) && (rows_o[k*RW + N + 3] == 1'b0))
        else $error("row tail constant wrong");
    end
    for (int k = 0; k < R; k++) begin
      assert_zero_x_R1: assert ((x_i != '0) || (&rows_o[k*RW +: N+1]) || (~|rows_o[k*RW +: N+1]))
        else $error("zero multiplicand gives mixed row");
    end
  end
endmodule

bind booth_u4_mul booth_u4_mul_chk #(.N(N)) u_chk (
  .x_i(x_i), .y_i(y_i), .rows_o(rows_o), .prod_o(prod_o)
);

// File: tb/sim_booth_u4_mul.sv
module sim_lane #(
  parameter int N       = 4,
  parameter bit EXHAUST = 1'b1,
  parameter int NRAND   = 2000
) (
  input  logic clk,
  output int   checks_o,
  output int   errs_o,
  output logic done_o
);
  localparam int R  = (N + 2) / 2;
  localparam int RW = N + 4;

  logic [N-1:0]         x, y;
  logic [R*RW-1:0]      rows;
  logic [2*N-1:0]       prod;

  booth_u4_mul #(.N(N)) u0 (.x_i(x), .y_i(y), .rows_o(rows), .prod_o(prod));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks_o++;
    if (!ok) begin
      errs_o++;
      $display("FAIL %s N=%0d x=%0d y=%0d act=%0h exp=%0h", req, N, x, y, act, exp);
    end
  endtask

  task automatic run_vec(input logic [N-1:0] xv, input logic [N-1:0] yv);
    logic [2*R+1:0] yz;
    @(posedge clk);
    x = xv;
    y = yv;
    @(negedge clk);
    yz = (2*R+2)'({yv, 1'b0});
    for (int k = 0; k < R; k++) begin
      int d, mag;
      logic s;
      logic [N:0] m, dexp;
      logic [RW-1:0] r;
      logic [2:0] tail;
      longint sv;
      r = rows[k*RW +: RW];
      s = yz[2*k+2];
      d = int'(yz[2*k]) + int'(yz[2*k+1]) - 2 * int'(yz[2*k+2]);
      mag = (d < 0) ? -d : d;
      m = (N+1)'(longint'(mag) * longint'(xv));
      dexp = s ? ~m : m;
      chk(r[0] == dexp[0], "R2", longint'(r[0]), longint'(dexp[0]));
      if (N > 1)
        chk(r[N-1:1] == dexp[N-1:1], "R3", longint'(r[N-1:1]), longint'(dexp[N-1:1]));
      chk(r[N] == dexp[N], "R4", longint'(r[N]), longint'(dexp[N]));
      sv = longint'(r[N:0]) - (s ? (longint'(1) << (N + 1)) : 0) + longint'(s);
      chk(sv == longint'(d) * longint'(xv), "R1", sv, longint'(d) * longint'(xv));
      if (k == 0) begin
        tail = {~s, s, s};
        chk(r[N+3:N+1] == tail, "R5", longint'(r[N+3:N+1]), longint'(tail));
      end else begin
        tail = {1'b0, 1'b1, ~s};
        chk(r[N+3:N+1] == tail, "R6", longint'(r[N+3:N+1]), longint'(tail));
      end
      if (k == R - 1) chk(s == 1'b0, "R7", longint'(s), 0);
    end
    chk(prod == (2*N)'(longint'(xv) * longint'(yv)), "R8", longint'(prod), longint'(xv) * longint'(yv));
  endtask

  initial begin
    checks_o = 0;
    errs_o   = 0;
    done_o   = 1'b0;
    x = '0;
    y = '0;
    @(negedge clk);
    chk(prod == '0, "R8", longint'(prod), 0);  // idle state: zero operands
    if (EXHAUST) begin
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          run_vec(N'(a), N'(b));
    end else begin
      run_vec('1, '1);
      run_vec('1, '0);
      run_vec('0, '1);
      run_vec({1'b1, {(N-1){1'b0}}}, '1);
      for (int i = 0; i < NRAND; i++)
        run_vec(N'($urandom), N'($urandom));
    end
    done_o = 1'b1;
  end
endmodule

module sim_booth_u4_mul;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int c4, e4, c5, e5, c16, e16;
  logic d4, d5, d16;

  sim_lane #(.N(4),  .EXHAUST(1'b1)) u0  (.clk(clk), .checks_o(c4),  .errs_o(e4),  .done_o(d4));
  sim_lane #(.N(5),  .EXHAUST(1'b1)) u1  (.clk(clk), .checks_o(c5),  .errs_o(e5),  .done_o(d5));
  sim_lane #(.N(16), .EXHAUST(1'b0)) u2  (.clk(clk), .checks_o(c16), .errs_o(e16), .done_o(d16));

  initial begin
    int cyc;
    int wd_err;
    cyc = 0;
    wd_err = 0;
    while (!(d4 === 1'b1 && d5 === 1'b1 && d16 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 150000) begin
      wd_err = 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", c4 + c5 + c16 + wd_err, e4 + e5 + e16 + wd_err);
    $finish;
  end
endmodule